// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing strobes for a serial receiver/transmitter from the bus clock. It produces two strobes. The first is a sixteen-times-oversampling strobe. The second is a bit-rate strobe that fires once for every sixteen oversampling strobes. The division ratio is a fixed-point number, made of a 16-bit whole part and a 6-bit binary fraction, so its resolution is 1/64 of a bus clock.

A non-integer ratio cannot be met by every single interval. The generator therefore mixes intervals of `I` and `I+1` bus clocks, where `I` is the whole part. A 6-bit accumulator decides which intervals are lengthened, so the average interval is exactly `I + F/64` bus clocks, where `F` is the fraction field. Both divisor fields are captured into internal copies. A new value takes effect at a strobe boundary, or straight away while the block is disabled.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and after reset while `enable` is low, `os_tick` and `bit_tick` are both 0.
- R2: After `enable` rises, interval k (k = 0, 1, 2, ...) lasts `I + s_k` bus clocks. Here s_k is 1 when `((k*F) mod 64) + F >= 64` and 0 otherwise. The first strobe appears on the `I + s_0`-th rising edge counted from the first edge at which `enable` is sampled high.
- R3: Any 64 consecutive oversampling intervals add up to exactly `64*I + F` bus clocks.
- R4: Each `os_tick` pulse lasts one bus clock. When `I >= 2`, every pulse is preceded by a low cycle. When `I = 1` and `F = 0`, `os_tick` is high on every cycle.
- R5: `bit_tick` is high only together with `os_tick`, and only on oversampling strobes numbered 16, 32, 48, and so on after enable.
- R6: A divisor change made while the block is enabled leaves the interval in progress unchanged. The change first applies to the interval that follows the next strobe.
- R7: While the captured whole part is 0, no strobe is produced. Once a non-zero whole part is applied, the first strobe follows on the edge `I + 1` cycles later: one cycle to capture the value, then `I` counted cycles.
- R8: Taking `enable` low suppresses both strobes from the next edge onward. It also clears the interval counter, the fraction accumulator and the strobe count. The next enable therefore starts again at interval k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control. While it is low, the divisor is reloaded every cycle and all state is cleared. |
| div_int | input | 16 | Whole part of the divisor, in bus clocks |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 bus clock |
| os_tick | output | 1 | Oversampling strobe, one bus clock wide |
| bit_tick | output | 1 | Bit-rate strobe, coinciding with every 16th `os_tick` |

## Verification
The bound checker watches, on every cycle, the relations that hold regardless of the divisor value. Both strobes are silent after a disabled cycle. `bit_tick` never appears without `os_tick` and lands exactly on each sixteenth strobe. Back-to-back strobes occur only with a captured whole part of 1. No strobe follows a cycle with a zero whole part. The exact interval lengths, the 64-interval totals, the deferred take-up of a changed divisor, and the restart after disable all depend on the programmed values. Only the bench shows these, by sweeping every fraction for several small whole parts and timing each strobe against arithmetic expectations.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              os_tick,
  output logic              bit_tick
);
  localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [INT_W-1:0]  sh_int;
  logic [FRAC_W-1:0] sh_frac;
  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [OVS_W-1:0]  ovs;

  logic [FRAC_W:0]   acc_sum;
  logic              stretch;
  logic [INT_W-1:0]  last;
  logic              running;
  logic              hit;
  logic              reload;

  assign acc_sum = {1'b0, acc} + {1'b0, sh_frac};
  assign stretch = acc_sum[FRAC_W];
  assign last    = sh_int - INT_W'(1) + INT_W'(stretch);
  assign running = enable && (sh_int != '0);
  assign hit     = running && (cnt == last);
  assign reload  = !enable || hit || (sh_int == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_int   <= '0;
      sh_frac  <= '0;
      cnt      <= '0;
      acc      <= '0;
      ovs      <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      if (reload) begin
        sh_int  <= div_int;
        sh_frac <= div_frac;
      end

      if (!running || hit) cnt <= '0;
      else                 cnt <= cnt + INT_W'(1);

      if (!enable)  acc <= '0;
      else if (hit) acc <= acc_sum[FRAC_W-1:0];

      if (!enable) ovs <= '0;
      else if (hit) ovs <= (ovs == OVS_W'(OVS - 1)) ? '0 : ovs + OVS_W'(1);

      os_tick  <= hit;
      bit_tick <= hit && (ovs == OVS_W'(OVS - 1));
    end
  end
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int INT_W = 16,
  parameter int OVS   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             os_tick,
  input logic             bit_tick,
  input logic [INT_W-1:0] sh_int
);
  logic [7:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) seen <= '0;
    else if (os_tick)      seen <= (seen == 8'(OVS - 1)) ? '0 : seen + 8'd1;
  end

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!os_tick && !bit_tick));

  a_r5_bit_needs_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  a_r5_bit_every16: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> (bit_tick == (seen == 8'(OVS - 1))));

  a_r7_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sh_int == '0) |=> !os_tick);

  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && $past(os_tick)) |-> ($past(sh_int) == INT_W'(1)));
endmodule

bind frac_baud_gen frac_baud_chk #(.INT_W(INT_W), .OVS(OVS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .os_tick(os_tick), .bit_tick(bit_tick), .sh_int(sh_int)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic        os_tick, bit_tick;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;
  int lens [0:255];

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .div_int(div_int), .div_frac(div_frac),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2 R3 R4 R5: time n strobes after enable against the accumulator arithmetic
  task automatic run_cfg(input int I, input int F, input int n);
    int t = 0, prev = 0, k = 0, acc_e = 0;
    enable = 1'b0;
    div_int = 16'(I);
    div_frac = 6'(F);
    step();
    step();
    enable = 1'b1;
    while (k < n && t < (I + 2) * (n + 2)) begin
      step();
      t++;
      if (os_tick) begin
        int s = ((acc_e + F) >= 64) ? 1 : 0;
        int gap = t - prev;
        acc_e = (acc_e + F) % 64;
        chk(gap == I + s, $sformatf("R2 I=%0d F=%0d k=%0d interval", I, F, k), gap, I + s);
        if (I >= 2 && k > 0)
          chk(gap >= 2, $sformatf("R4 I=%0d F=%0d k=%0d pulse gap", I, F, k), gap, 2);
        chk(bit_tick == ((k % 16) == 15), $sformatf("R5 I=%0d F=%0d k=%0d bit_tick", I, F, k),
            int'(bit_tick), int'((k % 16) == 15));
        lens[k] = gap;
        prev = t;
        k++;
      end else if (bit_tick) begin
        chk(1'b0, $sformatf("R5 I=%0d F=%0d bit_tick without os_tick", I, F), 1, 0);
      end
    end
    chk(k == n, $sformatf("R2 I=%0d F=%0d strobe count", I, F), k, n);
    for (int w = 0; w + 64 <= k; w++) begin
      int sum = 0;
      for (int j = 0; j < 64; j++) sum += lens[w + j];
      chk(sum == 64 * I + F, $sformatf("R3 I=%0d F=%0d window %0d", I, F, w), sum, 64 * I + F);
    end
    enable = 1'b0;
    step();
  endtask

  initial begin
    int t;
    int ticks;
    // R1 reset and disabled state
    repeat (3) begin
      step();
      chk(!os_tick && !bit_tick, "R1 during reset", int'(os_tick | bit_tick), 0);
    end
    rst_n = 1'b1;
    div_int = 16'd3;
    repeat (5) begin
      step();
      chk(!os_tick && !bit_tick, "R1 disabled after reset", int'(os_tick | bit_tick), 0);
    end

    // R2 R3 R5: near-exhaustive fraction sweep for small whole parts
    for (int i = 1; i <= 3; i++)
      for (int f = 0; f < 64; f++)
        run_cfg(i, f, 66);
    run_cfg(300, 37, 66);

    // R4: unity divisor keeps os_tick high every cycle
    enable = 1'b0; div_int = 16'd1; div_frac = 6'd0;
    step();
    enable = 1'b1;
    for (int c = 0; c < 20; c++) begin
      step();
      chk(os_tick == 1'b1, $sformatf("R4 unity cycle %0d", c), int'(os_tick), 1);
    end

    // R6: divisor change mid-run applies after the next strobe
    enable = 1'b0; div_int = 16'd4; div_frac = 6'd0;
    step();
    enable = 1'b1;
    t = 0; ticks = 0;
    while (ticks < 2 && t < 50) begin step(); t++; if (os_tick) ticks++; end
    chk(t == 8, "R6 second strobe before change", t, 8);
    div_int = 16'd7;
    t = 0;
    while (t < 50) begin step(); t++; if (os_tick) break; end
    chk(t == 4, "R6 interval in progress keeps old divisor", t, 4);
    t = 0;
    while (t < 50) begin step(); t++; if (os_tick) break; end
    chk(t == 7, "R6 following interval uses new divisor", t, 7);

    // R7: zero whole part idles, then starts once non-zero
    enable = 1'b0; div_int = 16'd0; div_frac = 6'd5;
    step();
    enable = 1'b1;
    ticks = 0;
    for (int c = 0; c < 100; c++) begin step(); if (os_tick || bit_tick) ticks++; end
    chk(ticks == 0, "R7 no strobes with zero whole part", ticks, 0);
    div_int = 16'd5; div_frac = 6'd0;
    t = 0;
    while (t < 50) begin step(); t++; if (os_tick) break; end
    chk(t == 6, "R7 first strobe after non-zero whole part", t, 6);

    // R8: disable silences and restarts from interval zero
    enable = 1'b0; div_int = 16'd10; div_frac = 6'd0;
    step();
    enable = 1'b1;
    ticks = 0;
    for (int c = 0; c < 25; c++) begin step(); if (os_tick) ticks++; end
    chk(ticks == 2, "R8 strobes before disable", ticks, 2);
    enable = 1'b0;
    div_int = 16'd6; div_frac = 6'd40;
    ticks = 0;
    for (int c = 0; c < 40; c++) begin step(); if (os_tick || bit_tick) ticks++; end
    chk(ticks == 0, "R8 no strobes while disabled", ticks, 0);
    enable = 1'b1;
    t = 0;
    while (t < 50) begin step(); t++; if (os_tick) break; end
    chk(t == 6, "R8 first strobe after re-enable", t, 6);
    t = 0;
    while (t < 50) begin step(); t++; if (os_tick) break; end
    chk(t == 7, "R8 second interval stretched by fresh accumulator", t, 7);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule